// File: doc/BRIEF.md
# Accumulator Memory-Reference Sequencer

This block is the multi-cycle control and datapath core of a small 16-bit accumulator machine. It takes instruction words from a single-port synchronous memory in program-counter order. Each word is split into a 12-bit operand address, a 3-bit operation code and a 1-bit indirection flag. The block carries out the seven operations that touch memory, using the accumulator (AC), a one-bit carry/extension flag (E) and the program counter (PC). When the indirection flag is set, one extra memory read turns the address field into the effective address.

Memory reads have one cycle of latency: a word appears on the read-data input in the cycle after its address was driven. Each state of the sequencer makes at most one memory access. The block does not execute words whose operation code is 111. It hands each such word to a neighbouring register/IO unit through a one-cycle strobe and then moves on to the next fetch. A `run` input starts execution from idle. When `run` is dropped, the block finishes the instruction in progress and parks.

Top module: `mref_seq`

## Requirements
- R1: While reset is asserted and afterwards with `run` low, PC, AC and E read zero, `mem_we` and `rio_stb` stay low, and PC does not move.
- R2: Every instruction starts with a read at address PC, and PC advances by exactly one in that fetch cycle. Later instructions follow in address order.
- R3: With bit 15 of the word set, the block reads the word stored at the address held in bits 11..0. Bits 11..0 of that word become the effective address, and the block never writes to the pointer word.
- R4: Operation code 000 replaces AC with AC bitwise-AND the memory word at the effective address. Code 010 loads that word into AC. Neither changes E.
- R5: Code 001 adds the memory word to AC modulo 2^16 and stores the carry-out of bit 15 in E.
- R6: Code 011 writes AC to the effective address and leaves AC unchanged.
- R7: Code 100 sets PC to the effective address. Code 101 writes the already-advanced PC, zero-extended to 16 bits, to the effective address, and sets PC to the effective address plus one.
- R8: Code 110 writes the memory word plus one (modulo 2^16) back to the effective address. When the result is zero, PC advances by one more, so the next instruction is skipped.
- R9: A word whose bits 14..12 are 111 raises `rio_stb` for one cycle, with the whole word on `rio_word`, whatever bit 15 holds. It causes no memory write and changes neither AC nor E.
- R10: When `run` goes low, the instruction in progress completes, after which PC holds still and no memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start execution and keep it going; low parks the block after the current instruction |
| mem_addr | output | 12 | Memory address for the access of the current state |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| pc | output | 12 | Program counter |
| ac | output | 16 | Accumulator |
| e_flag | output | 1 | Carry/extension flag |
| rio_stb | output | 1 | One-cycle strobe for a register/IO word |
| rio_word | output | 16 | The word handed over with the strobe |

## Verification
Two functions fall on the same clock edge in this block. When an increment-and-skip wraps to zero, the write-back of the zero word and the extra PC step happen together. A subroutine call likewise stores the return address and jumps to the target in one cycle. The bench provokes the first with a counter word of 0xFFFF followed by a self-branch that only a missed skip would reach. It provokes the second with a call whose return is an indirect branch through the stored word. In both cases the final PC and the memory contents are checked, and these values only come out right if both halves of that cycle acted.

// File: rtl/mref_pkg.sv
package mref_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_ADD = 3'd1,
    OP_LDA = 3'd2,
    OP_STA = 3'd3,
    OP_BUN = 3'd4,
    OP_BSA = 3'd5,
    OP_ISZ = 3'd6,
    OP_RIO = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DECODE,
    S_PTR_RD,
    S_PTR_LAT,
    S_EXEC,
    S_OPND,
    S_WBACK
  } st_e;

endpackage

// File: rtl/mref_decode.sv
module mref_decode
  import mref_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic [DW-1:0] word,
  output op_e           op,
  output logic          ind,
  output logic [AW-1:0] field,
  output logic          is_rio
);
  // opcode sits directly above the address field, mode bit on top
  assign field  = word[AW-1:0];
  assign op     = op_e'(word[AW+2:AW]);
  assign ind    = word[DW-1];
  assign is_rio = (op == OP_RIO);
endmodule

// File: rtl/mref_alu.sv
module mref_alu
  import mref_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          e_in,
  output logic [DW-1:0] acc_nx,
  output logic          e_nx,
  output logic [DW-1:0] inc_val
);
  function automatic logic [DW:0] f_sum(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [DW-1:0] f_inc(input logic [DW-1:0] a);
    return a + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  logic [DW:0] sum;

  always_comb begin
    sum    = f_sum(acc, opnd);
    acc_nx = acc;
    e_nx   = e_in;
    case (op)
      OP_AND:  acc_nx = acc & opnd;
      OP_ADD:  {e_nx, acc_nx} = sum;
      OP_LDA:  acc_nx = opnd;
      default: ;
    endcase
  end

  assign inc_val = f_inc(opnd);
endmodule

// File: rtl/mref_seq.sv
module mref_seq
  import mref_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ac,
  output logic          e_flag,
  output logic          rio_stb,
  output logic [DW-1:0] rio_word
);
  localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] ZERO_D = '0;

  st_e           st;
  logic [DW-1:0] ir, dr;
  logic [AW-1:0] ear;
  logic [DW-1:0] cur_word;
  op_e           op;
  logic          ind, is_rio;
  logic [AW-1:0] field;
  logic [DW-1:0] acc_nx, inc_val;
  logic          e_nx;
  st_e           st_after;

  // named events for the checker
  logic ev_fetch, ev_ind, ev_skip, ev_call, ev_store;

  // the fresh word is decoded straight from memory in DECODE, else the held copy
  assign cur_word = (st == S_DECODE) ? mem_rdata : ir;

  mref_decode #(.AW(AW), .DW(DW)) u_dec (
    .word   (cur_word),
    .op     (op),
    .ind    (ind),
    .field  (field),
    .is_rio (is_rio)
  );

  mref_alu #(.DW(DW)) u_alu (
    .op      (op),
    .acc     (ac),
    .opnd    (mem_rdata),
    .e_in    (e_flag),
    .acc_nx  (acc_nx),
    .e_nx    (e_nx),
    .inc_val (inc_val)
  );

  assign st_after = run ? S_FETCH : S_IDLE;

  assign ev_fetch = (st == S_FETCH);
  assign ev_ind   = (st == S_PTR_RD);
  assign ev_skip  = (st == S_WBACK) && (dr == ZERO_D);
  assign ev_call  = (st == S_EXEC) && (op == OP_BSA);
  assign ev_store = (st == S_EXEC) && (op == OP_STA);

  assign mem_addr = (st == S_FETCH) ? pc : ear;
  assign mem_we   = ev_call || ev_store || (st == S_WBACK);

  always_comb begin
    if (st == S_WBACK)  mem_wdata = dr;
    else if (ev_call)   mem_wdata = {{(DW-AW){1'b0}}, pc};
    else                mem_wdata = ac;
  end

  assign rio_stb  = (st == S_DECODE) && is_rio;
  assign rio_word = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pc     <= '0;
      ac     <= '0;
      e_flag <= 1'b0;
      ir     <= '0;
      dr     <= '0;
      ear    <= '0;
    end else begin
      case (st)
        S_IDLE: if (run) st <= S_FETCH;
        S_FETCH: begin
          pc <= pc + ONE_A;
          st <= S_DECODE;
        end
        S_DECODE: begin
          ir  <= mem_rdata;
          ear <= field;
          if (is_rio)   st <= st_after;
          else if (ind) st <= S_PTR_RD;
          else          st <= S_EXEC;
        end
        S_PTR_RD: st <= S_PTR_LAT;
        S_PTR_LAT: begin
          ear <= mem_rdata[AW-1:0];
          st  <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_STA: st <= st_after;
            OP_BUN: begin
              pc <= ear;
              st <= st_after;
            end
            OP_BSA: begin
              pc <= ear + ONE_A;
              st <= st_after;
            end
            default: st <= S_OPND;
          endcase
        end
        S_OPND: begin
          if (op == OP_ISZ) begin
            dr <= inc_val;
            st <= S_WBACK;
          end else begin
            ac     <= acc_nx;
            e_flag <= e_nx;
            st     <= st_after;
          end
        end
        S_WBACK: begin
          if (dr == ZERO_D) pc <= pc + ONE_A;
          st <= st_after;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mref_seq_chk.sv
module mref_seq_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] ac,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          rio_stb,
  input logic          ev_fetch,
  input logic          ev_ind,
  input logic          ev_skip,
  input logic          ev_call,
  input logic          ev_store
);
  localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> pc == ($past(pc) + ONE_A));

  p_ptr_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ind |-> !mem_we);

  p_store_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |-> (mem_we && mem_wdata == ac));

  p_call_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |-> (mem_we && mem_wdata[AW-1:0] == pc));

  p_call_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |=> pc == ($past(mem_addr) + ONE_A));

  p_skip_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> pc == ($past(pc) + ONE_A));

  p_rio_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rio_stb |-> !mem_we);
endmodule

bind mref_seq mref_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc        (pc),
  .ac        (ac),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .rio_stb   (rio_stb),
  .ev_fetch  (ev_fetch),
  .ev_ind    (ev_ind),
  .ev_skip   (ev_skip),
  .ev_call   (ev_call),
  .ev_store  (ev_store)
);

// File: tb/sim_mref_seq.sv
`timescale 1ns/1ps
module sim_mref_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [11:0] pc;
  logic [15:0] ac;
  logic        e_flag;
  logic        rio_stb;
  logic [15:0] rio_word;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wr_cnt = 0;
  int stb_cnt = 0;
  logic [15:0] stb_w [0:3];
  logic [15:0] mem [0:255];

  always #5 clk = ~clk;

  mref_seq u0 (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc(pc), .ac(ac), .e_flag(e_flag),
    .rio_stb(rio_stb), .rio_word(rio_word)
  );

  // single-port synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) wr_cnt = wr_cnt + 1;
      if (rio_stb) begin
        stb_w[stb_cnt % 4] = rio_word;
        stb_cnt = stb_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  // reset, run for a while, drop run, let the block park
  task automatic run_prog(input int ncyc);
    rst_n = 1'b0;
    run = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr_cnt = 0;
    stb_cnt = 0;
    run = 1'b1;
    repeat (ncyc) @(negedge clk);
    run = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    run = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", {20'd0, pc}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 pc idle", {20'd0, pc}, 32'd0);
    chk("R1 ac idle", {16'd0, ac}, 32'd0);
    chk("R1 e idle", {31'd0, e_flag}, 32'd0);
    chk("R1 no write/strobe", {30'd0, mem_we, rio_stb}, 32'd0);
  endtask

  task automatic t_logic_arith();
    logic [11:0] pc_a;
    clear_mem();
    mem[0] = 16'h2020; // LDA 0x20
    mem[1] = 16'h0021; // AND 0x21
    mem[2] = 16'h1022; // ADD 0x22
    mem[3] = 16'h4003; // BUN 3
    mem[8'h20] = 16'hF0F0;
    mem[8'h21] = 16'hFF00;
    mem[8'h22] = 16'h1234;
    run_prog(60);
    chk("R4/R5 ac after lda-and-add", {16'd0, ac}, 32'h0000_0234);
    chk("R5 carry into e", {31'd0, e_flag}, 32'd1);
    pc_a = pc;
    chk("R10 parked pc", {20'd0, pc_a}, 32'd3);
    wr_cnt = 0;
    repeat (10) @(negedge clk);
    chk("R10 pc holds", {20'd0, pc}, {20'd0, pc_a});
    chk("R10 no writes while parked", wr_cnt, 32'd0);
  endtask

  task automatic t_and_only();
    clear_mem();
    mem[0] = 16'h2010; // LDA 0x10
    mem[1] = 16'h0011; // AND 0x11
    mem[2] = 16'h4002;
    mem[8'h10] = 16'h0FF0;
    mem[8'h11] = 16'h3C3C;
    run_prog(40);
    chk("R4 and result", {16'd0, ac}, 32'h0000_0C30);
    chk("R4 e untouched", {31'd0, e_flag}, 32'd0);
  endtask

  task automatic t_indirect();
    clear_mem();
    mem[0] = 16'hA030; // LDA @0x30
    mem[1] = 16'hB031; // STA @0x31
    mem[2] = 16'h4002;
    mem[8'h30] = 16'h0040;
    mem[8'h31] = 16'h0050;
    mem[8'h40] = 16'hBEEF;
    run_prog(60);
    chk("R3 indirect load", {16'd0, ac}, 32'h0000_BEEF);
    chk("R3 pointer intact", {16'd0, mem[8'h30]}, 32'h0000_0040);
    chk("R6 indirect store", {16'd0, mem[8'h50]}, 32'h0000_BEEF);
    chk("R6 ac kept", {16'd0, ac}, 32'h0000_BEEF);
  endtask

  task automatic t_call();
    clear_mem();
    mem[0] = 16'h5060;       // BSA 0x60
    mem[1] = 16'h4001;       // BUN 1
    mem[8'h61] = 16'hC060;   // BUN @0x60 (return)
    run_prog(60);
    chk("R7 return address stored", {16'd0, mem[8'h60]}, 32'h0000_0001);
    chk("R7 returned via link", {20'd0, pc}, 32'd1);
  endtask

  task automatic t_isz();
    clear_mem();
    mem[0] = 16'h6070; // ISZ 0x70 (wraps, skip)
    mem[1] = 16'h4001; // trap if skip is missed
    mem[2] = 16'h6071; // ISZ 0x71 (no skip)
    mem[3] = 16'h4003;
    mem[8'h70] = 16'hFFFF;
    mem[8'h71] = 16'h0005;
    run_prog(60);
    chk("R8 wrap to zero", {16'd0, mem[8'h70]}, 32'd0);
    chk("R8 plain increment", {16'd0, mem[8'h71]}, 32'd6);
    chk("R8 skip taken once", {20'd0, pc}, 32'd3);
  endtask

  task automatic t_rio();
    clear_mem();
    mem[0] = 16'h2020; // LDA 0x20
    mem[1] = 16'h7020;
    mem[2] = 16'hF400;
    mem[3] = 16'h4003;
    mem[8'h20] = 16'h5555;
    run_prog(60);
    chk("R9 strobe count", stb_cnt, 32'd2);
    chk("R9 first word", {16'd0, stb_w[0]}, 32'h0000_7020);
    chk("R9 second word", {16'd0, stb_w[1]}, 32'h0000_F400);
    chk("R9 no memory write", wr_cnt, 32'd0);
    chk("R9 ac untouched", {16'd0, ac}, 32'h0000_5555);
    chk("R2 sequential fetch", {20'd0, pc}, 32'd3);
  endtask

  initial begin
    t_reset();
    t_logic_arith();
    t_and_only();
    t_indirect();
    t_call();
    t_isz();
    t_rio();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule